// File: doc/BRIEF.md
# Split-Write Double-Buffered Control Word Register

This block builds a 12-bit control word out of two writes over an 8-bit data bus. It then hands the whole word to its consumer in a single step. Each of two select strobes loads one part of a pending register. The low strobe loads the low byte. The high strobe loads the upper four bits, taken from the bottom nibble of the bus.

The output register never follows the pending register directly. It takes a copy only when a transfer strobe pulses. That strobe is the mains zero-crossing event, already brought into the system clock domain. Between transfer events the consumer, a phase-delay counter that loads `word_o`, always sees a complete word, never a half-written one.

All strobes are synchronous enables, sampled on the rising edge of `clk_i`.

Top module: `split_word_buffer`

## Requirements
- R1: While `rst_ni` is low, both the pending register and `word_o` are 0. A transfer issued before any write after reset leaves `word_o` at 0.
- R2: A cycle with `sel_lo_i` high stores `data_i[7:0]` into pending bits [7:0] and leaves pending bits [11:8] unchanged.
- R3: A cycle with `sel_hi_i` high stores `data_i[3:0]` into pending bits [11:8]. `data_i[7:4]` has no effect on any stored bit.
- R4: A cycle with `xfer_i` high makes `word_o` equal to the whole pending word after that clock edge.
- R5: In any cycle with `xfer_i` low, `word_o` holds its value, whatever the select strobes and `data_i` do.
- R6: When a select strobe and `xfer_i` are high in the same cycle, `word_o` takes the pending value from before that write. The write still lands in the pending register and appears at the next transfer.
- R7: When both select strobes are high in one cycle, the low part takes `data_i[7:0]` and the high part takes `data_i[3:0]`, both from the same byte.
- R8: Changes on `data_i` in cycles with both select strobes low do not alter the pending register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Host data byte |
| sel_lo_i | input | 1 | Store strobe for pending bits [7:0] |
| sel_hi_i | input | 1 | Store strobe for pending bits [11:8] |
| xfer_i | input | 1 | Zero-crossing transfer pulse, one clock wide |
| word_o | output | 12 | Word presented to the consumer |

## Verification
The assertions take for granted that every strobe is already synchronous to `clk_i` and free of glitches. They also assume that `xfer_i` lasts a single cycle per zero crossing, so that each transfer copies one settled pending value.

The bench meets these assumptions by changing the strobes and `data_i` only on the falling edge. Each strobe is held for exactly one clock cycle. Bus changes made with the strobes low are confined to cycles in which the design is expected to ignore them.

// File: rtl/swb_pkg.sv
package swb_pkg;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned WORD_W_DEF = 12;
  localparam int unsigned NPARTS     = 2;
endpackage

// File: rtl/swb_field_reg.sv
module swb_field_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/swb_hold.sv
module swb_hold
  import swb_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned WORD_W = WORD_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic [NPARTS-1:0] sel_i,
  output logic [WORD_W-1:0] hold_o
);
  // part i covers word bits starting at i*DATA_W; the top part may be narrower
  for (genvar i = 0; i < NPARTS; i++) begin : g_part
    localparam int unsigned REM = WORD_W - i*DATA_W;
    localparam int unsigned PW  = (REM < DATA_W) ? REM : DATA_W;
    swb_field_reg #(.W(PW)) u_part (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (sel_i[i]),
      .d_i    (data_i[PW-1:0]),
      .q_o    (hold_o[i*DATA_W +: PW])
    );
  end
endmodule

// File: rtl/split_word_buffer.sv
module split_word_buffer
  import swb_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned WORD_W = WORD_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              sel_lo_i,
  input  logic              sel_hi_i,
  input  logic              xfer_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] hold_w;

  swb_hold #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .sel_i  ({sel_hi_i, sel_lo_i}),
    .hold_o (hold_w)
  );

  // second stage loads only on the zero-crossing pulse
  swb_field_reg #(.W(WORD_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (xfer_i),
    .d_i    (hold_w),
    .q_o    (word_o)
  );
endmodule

// File: rtl/swb_chk.sv
module swb_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WORD_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] data_i,
  input logic              sel_lo_i,
  input logic              sel_hi_i,
  input logic              xfer_i,
  input logic [WORD_W-1:0] hold_i,
  input logic [WORD_W-1:0] word_i
);
  localparam int unsigned HI_W = WORD_W - DATA_W;

  a_r1_reset_zero: assert property (@(posedge clk_i)
    !rst_ni |-> (word_i == '0 && hold_i == '0));

  a_r2_lo_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_lo_i |=> hold_i[DATA_W-1:0] == $past(data_i));

  a_r3_hi_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_hi_i |=> hold_i[WORD_W-1:DATA_W] == $past(data_i[HI_W-1:0]));

  // R6: the copy uses the pending value sampled before any same-cycle write
  a_r4_xfer_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i |=> word_i == $past(hold_i));

  a_r5_hold_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_i |=> $stable(word_i));

  a_r8_lo_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_lo_i |=> $stable(hold_i[DATA_W-1:0]));

  a_r8_hi_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_hi_i |=> $stable(hold_i[WORD_W-1:DATA_W]));
endmodule

bind split_word_buffer swb_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .data_i   (data_i),
  .sel_lo_i (sel_lo_i),
  .sel_hi_i (sel_hi_i),
  .xfer_i   (xfer_i),
  .hold_i   (hold_w),
  .word_i   (word_o)
);

// File: tb/tb_split_word_buffer.sv
`timescale 1ns/1ps
module tb_split_word_buffer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  data_i = '0;
  logic        sel_lo_i = 1'b0;
  logic        sel_hi_i = 1'b0;
  logic        xfer_i = 1'b0;
  logic [11:0] word_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  split_word_buffer dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i),
    .sel_lo_i(sel_lo_i), .sel_hi_i(sel_hi_i), .xfer_i(xfer_i), .word_o(word_o)
  );

  task automatic check(input string req, input logic [11:0] exp);
    checks++;
    if (word_o !== exp) begin
      errors++;
      $display("FAIL %s: word_o=%03h expected=%03h", req, word_o, exp);
    end
  endtask

  // drive one strobed cycle at the falling edge; return at the next falling edge
  task automatic cyc(input logic lo, input logic hi, input logic xf, input logic [7:0] d);
    data_i = d; sel_lo_i = lo; sel_hi_i = hi; xfer_i = xf;
    @(negedge clk_i);
    sel_lo_i = 1'b0; sel_hi_i = 1'b0; xfer_i = 1'b0;
  endtask

  task automatic t_reset;
    check("R1", 12'h000);
    cyc(0, 0, 1, 8'hFF);
    check("R1", 12'h000);
  endtask

  task automatic t_basic;
    cyc(1, 0, 0, 8'hA5);
    check("R5", 12'h000);
    cyc(0, 1, 0, 8'h3C);
    check("R5", 12'h000);
    cyc(0, 0, 1, 8'h00);
    check("R2", 12'hCA5);
    check("R4", 12'hCA5);
  endtask

  task automatic t_hi_nibble;
    cyc(0, 1, 0, 8'hF2);
    cyc(0, 0, 1, 8'h00);
    check("R3", 12'h2A5);
  endtask

  task automatic t_same_cycle;
    cyc(1, 0, 0, 8'h77);
    check("R5", 12'h2A5);
    cyc(1, 0, 1, 8'h11);
    check("R6", 12'h277);
    cyc(0, 0, 1, 8'h00);
    check("R6", 12'h211);
  endtask

  task automatic t_both;
    cyc(1, 1, 0, 8'h9B);
    cyc(0, 0, 1, 8'h00);
    check("R7", 12'hB9B);
  endtask

  task automatic t_idle_bus;
    for (int i = 0; i < 4; i++) begin
      data_i = 8'h40 + 8'(i);
      @(negedge clk_i);
      check("R5", 12'hB9B);
    end
    cyc(0, 0, 1, 8'hEE);
    check("R8", 12'hB9B);
  endtask

  task automatic t_mid_reset;
    cyc(1, 1, 0, 8'h5D);
    rst_ni = 1'b0;
    #3;
    check("R1", 12'h000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    cyc(0, 0, 1, 8'h00);
    check("R1", 12'h000);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_hi_nibble();
    t_same_cycle();
    t_both();
    t_idle_bus();
    t_mid_reset();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule